// File: doc/BRIEF.md
# Write-Side Bus Slave with Early Data Acceptance

This block is the write half of an AXI4 slave that lets write data run ahead of its address. The address, data and response channels are handled independently. Data beats that turn up before the address are parked in an internal first-in first-out queue. Once an address has been taken, the queue drains into a small word-organised register memory at one beat per clock. The memory word for each beat is computed from the start address and the transfer size. Byte strobes select which lanes of that word change.

The block counts the beats up to the one that carries the last-beat flag and compares that count with the burst length given with the address. A mismatch, a misaligned start address, a size wider than the data bus, or a burst type other than incrementing all produce an error response. A clean burst gets an OK response. Only one address is held at a time. The response stays up until the master takes it, and data for the next burst may keep filling the queue in the meantime. A read-out port exposes any memory word so that its contents can be observed.

Top module: `axi_early_wr_slave`

## Requirements
- R1: While `rst_n` is low, `awready`, `wready` and `bvalid` are low. In the cycle after reset is released, `awready` and `wready` are high and `bvalid` is low.
- R2: The data-channel signals (`wlast`, `wdata`, `wstrb`) have no effect while `wvalid` is low. A `wlast` pulse during a gap between beats neither ends nor shortens the burst.
- R3: A burst gives the same memory contents and response whether its data arrives before its address handshake, overlaps it, or follows it.
- R4: Up to `MAX_BEATS` (16) beats are buffered without an address. With 16 beats held and no address, `wready` is low.
- R5: At most one address is outstanding. `awready` is low from the cycle after an address handshake until the cycle after its response handshake.
- R6: Beat i of a burst writes the memory word at index `(awaddr + i*2^awsize)[7:2]`. Only the byte lanes whose `wstrb` bit is set are changed; bit k of the strobe covers data bits 8k+7..8k.
- R7: When the address is already held and the queue is empty, `bvalid` rises at the second rising edge after the edge that accepts the last beat.
- R8: Once `bvalid` is high, it stays high with a stable `bresp` until the edge on which `bready` is high, and it is low after that edge.
- R9: If the number of beats up to `wlast` differs from `awlen+1`, `bresp` is 2'b10. Beats past `awlen+1` are discarded, and after a short burst the remaining words keep their old contents.
- R10: A start address that is not a multiple of 2^`awsize`, an `awsize` above 2, or an `awburst` other than 2'b01 gives `bresp` 2'b10. No memory word is written for such a burst.
- R11: A burst with none of the faults above returns `bresp` 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | 8 | Byte start address of the burst |
| awlen | input | 8 | Beats in the burst minus one |
| awsize | input | 3 | Log2 of bytes per beat |
| awburst | input | 2 | Burst type; only 2'b01 (incrementing) is accepted |
| awvalid | input | 1 | Address valid |
| awready | output | 1 | Address accepted |
| wdata | input | 32 | Write data beat |
| wstrb | input | 4 | Byte-lane strobes |
| wlast | input | 1 | Final beat of the burst |
| wvalid | input | 1 | Data beat valid |
| wready | output | 1 | Data beat accepted (low when queue full) |
| bresp | output | 2 | Response: 2'b00 OK, 2'b10 error |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response taken |
| peek_idx | input | 6 | Memory word index to read out |
| peek_data | output | 32 | Memory word at `peek_idx`, combinational |

## Verification
A beat accepted on edge E is committed to memory at edge E+1 at the earliest, and its response rises at E+2. The bench drives every input at a falling edge and samples half a cycle later. For the response timing case it checks `bvalid` at the first, second and third falling edges after the accepting edge, and expects low, low, high. Memory contents are read only after the response handshake has completed, so every write they depend on has certainly landed. `wready` and `awready` are checked at the falling edge that follows the handshake which should change them.

// File: rtl/axi_early_wr_slave.sv
module axi_early_wr_slave #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            awaddr,
  input  logic [7:0]                   awlen,
  input  logic [2:0]                   awsize,
  input  logic [1:0]                   awburst,
  input  logic                         awvalid,
  output logic                         awready,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [DATA_W/8-1:0]          wstrb,
  input  logic                         wlast,
  input  logic                         wvalid,
  output logic                         wready,
  output logic [1:0]                   bresp,
  output logic                         bvalid,
  input  logic                         bready,
  input  logic [$clog2(MEM_WORDS)-1:0] peek_idx,
  output logic [DATA_W-1:0]            peek_data
);
  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);
  localparam int IDX_W  = $clog2(MAX_BEATS);
  localparam int CNT_W  = IDX_W + 1;
  localparam int MEM_AW = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] q_data [MAX_BEATS];
  logic [STRB_W-1:0] q_strb [MAX_BEATS];
  logic              q_last [MAX_BEATS];
  logic [IDX_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;

  logic              have_addr, pend, a_bad;
  logic [ADDR_W-1:0] a_addr;
  logic [7:0]        a_len;
  logic [2:0]        a_size;
  logic [8:0]        bcnt;
  logic [1:0]        resp_q;

  logic [DATA_W-1:0] mem [MEM_WORDS];

  logic push, pop, we, aw_hs, bad_in;
  logic [ADDR_W-1:0] beat_addr;
  logic [MEM_AW-1:0] widx;

  assign wready  = rst_n && (cnt != CNT_W'(MAX_BEATS));
  assign awready = rst_n && !have_addr && !pend && !bvalid;
  assign push    = wvalid && wready;
  assign pop     = have_addr && (cnt != '0);
  assign aw_hs   = awvalid && awready;

  assign bad_in  = (awburst != 2'b01) || (awsize > 3'(LANE_W)) ||
                   (|(awaddr & ADDR_W'((1 << awsize) - 1)));

  assign beat_addr = a_addr + (ADDR_W'(bcnt) << a_size);
  assign widx      = MEM_AW'(beat_addr >> LANE_W);
  assign we        = pop && !a_bad && (bcnt <= {1'b0, a_len});
  assign peek_data = mem[peek_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        q_data[wp] <= wdata;
        q_strb[wp] <= wstrb;
        q_last[wp] <= wlast;
        wp <= (wp == IDX_W'(MAX_BEATS - 1)) ? '0 : wp + 1'b1;
      end
      if (pop)
        rp <= (rp == IDX_W'(MAX_BEATS - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_addr <= 1'b0;
      pend      <= 1'b0;
      bvalid    <= 1'b0;
      bresp     <= 2'b00;
      resp_q    <= 2'b00;
      a_bad     <= 1'b0;
      a_addr    <= '0;
      a_len     <= '0;
      a_size    <= '0;
      bcnt      <= '0;
    end else begin
      if (aw_hs) begin
        have_addr <= 1'b1;
        a_addr    <= awaddr;
        a_len     <= awlen;
        a_size    <= awsize;
        a_bad     <= bad_in;
        bcnt      <= '0;
      end
      if (pop) begin
        if (bcnt != '1) bcnt <= bcnt + 1'b1;
        if (q_last[rp]) begin
          have_addr <= 1'b0;
          pend      <= 1'b1;
          resp_q    <= (a_bad || bcnt != {1'b0, a_len}) ? 2'b10 : 2'b00;
        end
      end
      if (pend) begin
        pend   <= 1'b0;
        bvalid <= 1'b1;
        bresp  <= resp_q;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < STRB_W; k++)
      if (we && q_strb[rp][k])
        mem[widx][8*k +: 8] <= q_data[rp][8*k +: 8];
  end
endmodule

// File: rtl/axi_early_wr_slave_chk.sv
module axi_early_wr_slave_chk #(
  parameter int MAX_BEATS = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        awvalid,
  input logic                        awready,
  input logic                        wvalid,
  input logic                        wready,
  input logic                        bvalid,
  input logic                        bready,
  input logic [1:0]                  bresp,
  input logic [$clog2(MAX_BEATS):0]  fifo_cnt,
  input logic                        have_addr
);
  a_r4_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt == ($clog2(MAX_BEATS)+1)'(MAX_BEATS) |-> !wready);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && wready |=> fifo_cnt != '0);

  a_r5_single_addr: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready |=> !awready && have_addr);

  a_r5_busy_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready);

  a_r8_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bresp));

  a_r11_resp_code: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00 || bresp == 2'b10));
endmodule

bind axi_early_wr_slave axi_early_wr_slave_chk #(.MAX_BEATS(MAX_BEATS)) chk_i (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready),
  .wvalid(wvalid), .wready(wready), .bvalid(bvalid), .bready(bready),
  .bresp(bresp), .fifo_cnt(cnt), .have_addr(have_addr)
);

// File: tb/axi_early_wr_slave_tb_top.sv
module axi_early_wr_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] awaddr = '0;
  logic [7:0] awlen = '0;
  logic [2:0] awsize = '0;
  logic [1:0] awburst = '0;
  logic awvalid = 1'b0, awready;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic wlast = 1'b0, wvalid = 1'b0, wready;
  logic [1:0] bresp;
  logic bvalid, bready = 1'b0;
  logic [5:0] peek_idx = '0;
  logic [31:0] peek_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_mem [64];

  always #10 clk = ~clk;

  axi_early_wr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
    .awburst(awburst), .awvalid(awvalid), .awready(awready), .wdata(wdata),
    .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  function automatic logic [31:0] bd(int tag, int i);
    return {tag[7:0], i[7:0], 16'hC35A ^ 16'(tag * 37 + i * 11)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(int tag, logic [7:0] addr, int len, int size, logic [1:0] burst,
                       int nbeats, logic [3:0] strb, output logic [1:0] resp);
    bit bad;
    bad = (burst != 2'b01) || (size > 2) || ((addr & 8'((1 << size) - 1)) != 0);
    resp = (bad || nbeats != len + 1) ? 2'b10 : 2'b00;
    if (!bad)
      for (int i = 0; i < nbeats && i <= len; i++) begin
        logic [7:0] ba;
        logic [31:0] d;
        ba = addr + 8'(i << size);
        d = bd(tag, i);
        for (int k = 0; k < 4; k++)
          if (strb[k]) exp_mem[ba[7:2]][8*k +: 8] = d[8*k +: 8];
      end
  endtask

  task automatic do_aw(logic [7:0] addr, int len, int size, logic [1:0] burst);
    awaddr = addr; awlen = 8'(len); awsize = 3'(size); awburst = burst; awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
  endtask

  task automatic do_w(int tag, int nbeats, logic [3:0] strb, bit gap);
    for (int i = 0; i < nbeats; i++) begin
      if (gap && i > 0) begin
        wvalid = 1'b0; wlast = 1'b1; wdata = '1; wstrb = '1;
        @(negedge clk);
      end
      wvalid = 1'b1; wdata = bd(tag, i); wstrb = strb; wlast = (i == nbeats - 1);
      while (!wready) @(negedge clk);
      @(negedge clk);
    end
    wvalid = 1'b0; wlast = 1'b0;
  endtask

  task automatic get_b(logic [1:0] exp, int hold, string req);
    logic [1:0] first;
    bready = 1'b0;
    while (!bvalid) @(negedge clk);
    first = bresp;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(bvalid == 1'b1, "R8", "bvalid held", 32'(bvalid), 32'd1);
      chk(bresp == first, "R8", "bresp stable", 32'(bresp), 32'(first));
      chk(awready == 1'b0, "R5", "awready while resp pending", 32'(awready), 32'd0);
    end
    chk(bresp == exp, req, "bresp", 32'(bresp), 32'(exp));
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk(bvalid == 1'b0, "R8", "bvalid after handshake", 32'(bvalid), 32'd0);
  endtask

  task automatic check_mem(string req);
    for (int j = 0; j < 64; j++) begin
      peek_idx = 6'(j);
      #1;
      chk(peek_data === exp_mem[j], req, $sformatf("mem[%0d]", j), peek_data, exp_mem[j]);
    end
  endtask

  task automatic run(int tag, logic [7:0] addr, int len, int size, logic [1:0] burst,
                     int nbeats, logic [3:0] strb, int mode, bit gap, int hold, string req);
    logic [1:0] er;
    case (mode)
      0: begin
        do_aw(addr, len, size, burst);
        chk(awready == 1'b0, "R5", "awready after accept", 32'(awready), 32'd0);
        do_w(tag, nbeats, strb, gap);
      end
      1: begin
        do_w(tag, nbeats, strb, gap);
        if (nbeats == 16)
          chk(wready == 1'b0, "R4", "wready with full buffer", 32'(wready), 32'd0);
        do_aw(addr, len, size, burst);
      end
      default: fork
        do_aw(addr, len, size, burst);
        do_w(tag, nbeats, strb, gap);
      join
    endcase
    model(tag, addr, len, size, burst, nbeats, strb, er);
    get_b(er, hold, req);
    check_mem(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] er;
    repeat (3) begin
      @(negedge clk);
      chk(!awready && !wready, "R1", "ready during reset", {awready, wready}, 32'd0);
    end
    chk(bvalid == 1'b0, "R1", "bvalid during reset", 32'(bvalid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(awready && wready && !bvalid, "R1", "after reset", {awready, wready, bvalid}, 32'b110);

    for (int b = 0; b < 4; b++)
      run(b + 1, 8'(b * 64), 15, 2, 2'b01, 16, 4'hF, 0, 1'b0, 0, "R11");

    for (int mode = 0; mode < 3; mode++)
      for (int len = 0; len < 16; len++)
        run(16 + mode * 16 + len, 8'((len * 12 + mode * 40) & 8'hFC), len, 2, 2'b01,
            len + 1, 4'hF, mode, 1'b0, 0, "R3");

    run(70, 8'h30, 4, 2, 2'b01, 5, 4'hF, 2, 1'b1, 0, "R2");
    run(71, 8'h10, 3, 2, 2'b01, 4, 4'b0101, 0, 1'b0, 0, "R6");
    run(72, 8'h22, 5, 1, 2'b01, 6, 4'b1100, 1, 1'b0, 0, "R6");
    run(73, 8'h13, 3, 0, 2'b01, 4, 4'b1000, 2, 1'b0, 0, "R6");
    run(74, 8'h80, 3, 2, 2'b01, 6, 4'hF, 1, 1'b0, 0, "R9");
    run(75, 8'hC0, 5, 2, 2'b01, 2, 4'hF, 0, 1'b0, 0, "R9");
    run(76, 8'h06, 1, 2, 2'b01, 2, 4'hF, 0, 1'b0, 0, "R10");
    run(77, 8'h40, 1, 3, 2'b01, 2, 4'hF, 1, 1'b0, 0, "R10");
    run(78, 8'h50, 1, 2, 2'b00, 2, 4'hF, 2, 1'b0, 0, "R10");
    run(79, 8'h60, 2, 2, 2'b01, 3, 4'hF, 0, 1'b0, 5, "R8");

    do_aw(8'hA0, 0, 2, 2'b01);
    @(negedge clk);
    wvalid = 1'b1; wlast = 1'b1; wdata = bd(80, 0); wstrb = 4'hF;
    @(negedge clk);
    wvalid = 1'b0; wlast = 1'b0;
    chk(bvalid == 1'b0, "R7", "bvalid one edge after beat", 32'(bvalid), 32'd0);
    @(negedge clk);
    chk(bvalid == 1'b0, "R7", "bvalid two edges after beat", 32'(bvalid), 32'd0);
    @(negedge clk);
    chk(bvalid == 1'b1, "R7", "bvalid three edges after beat", 32'(bvalid), 32'd1);
    model(80, 8'hA0, 0, 2, 2'b01, 1, 4'hF, er);
    get_b(er, 0, "R7");
    check_mem("R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule